// File: doc/BRIEF.md
# Byte-Wide Access Bridge for a 16-bit Timer Register Group

This block connects a CPU that has an 8-bit data bus to a group of four 16-bit timer registers: a free-running counter, two compare registers and a capture register. Each register is split across two byte addresses, one for the lower byte and one for the upper byte. One 8-bit holding latch is shared by the whole group. It lets software move a full 16-bit value in two bus cycles without tearing, as long as it keeps to the correct byte order.

To write, software first stores the upper byte, which only fills the holding latch. It then writes the lower byte, and the full word is committed in one clock edge. To read the counter or the capture register, software reads the lower byte first. That read also freezes the matching upper byte in the latch, and the next upper-byte read returns the frozen value. Compare registers are read directly in either byte order and do not touch the latch. The block also takes a count enable, which advances the counter, and a capture strobe with a 16-bit value, which loads the capture register. All four registers are available as outputs.

Top module: `timer_byte_bridge`

## Requirements
- R1: After synchronous reset, the counter, both compare registers, the capture register and the holding latch are all zero. A read of the counter upper-byte address returns 0x00.
- R2: A write to any upper-byte address (odd address 1, 3, 5 or 7) changes only the holding latch. No register output changes.
- R3: A write to a lower-byte address (even address 0, 2, 4 or 6) loads that register with {holding latch, written byte}. The new value is visible on the register output after that clock edge.
- R4: A read of the counter lower byte (address 0) or the capture lower byte (address 6) returns the live lower byte. On the same edge, it copies that register's live upper byte into the holding latch.
- R5: A read of the counter upper byte (address 1) or the capture upper byte (address 7) returns the holding latch, not the live upper byte.
- R6: Reads of compare A (addresses 2/3) or compare B (addresses 4/5) return the live register byte and leave the holding latch unchanged.
- R7: The holding latch is shared. An upper-byte write to any register supplies the upper half for a following lower-byte write to any other register.
- R8: With count enable high, the counter adds one per clock and wraps from 0xFFFF to 0x0000. A lower-byte write to the counter in the same cycle wins, and that cycle's increment is dropped.
- R9: A capture strobe loads the 16-bit capture input into the capture register. A lower-byte write to the capture register in the same cycle wins over the strobe.
- R10: A read of any address from 8 upward returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address (0..7 mapped, even = lower byte) |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| cnt_en | input | 1 | Counter increment enable |
| cap_stb | input | 1 | Capture strobe |
| cap_val | input | 16 | Value loaded on a capture strobe |
| cnt_q | output | 16 | Counter value |
| cmpa_q | output | 16 | Compare A value |
| cmpb_q | output | 16 | Compare B value |
| cap_q | output | 16 | Capture value |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume each strobe marks exactly one access, so a decoded lower-byte load and a latch snapshot never coincide. The bench drives every access through single-cycle read or write tasks separated by idle cycles, so the two strobes never overlap. Count enable and capture strobe are raised only at controlled points, so every expected counter and capture value can be worked out in advance from the number of enabled edges.

// File: rtl/timer_byte_bridge_pkg.sv
`timescale 1ns/1ps
package timer_byte_bridge_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int NUM_WIDE = 4;
    localparam int ADDR_W   = 4;
    localparam int SLOT_W   = $clog2(NUM_WIDE);

    typedef enum logic [SLOT_W-1:0] {
        SLOT_CNT  = 2'd0,
        SLOT_CMPA = 2'd1,
        SLOT_CMPB = 2'd2,
        SLOT_CAP  = 2'd3
    } slot_e;

    // Decoded view of one bus cycle
    typedef struct packed {
        logic [NUM_WIDE-1:0] ld_lo;   // lower-byte write commits the word
        logic [NUM_WIDE-1:0] snap;    // lower-byte read freezes the upper byte
        logic                hi_wr;   // upper-byte write fills the latch
        logic                hit;     // address inside the map
        logic                rd_hi;   // upper-byte half selected
        slot_e               slot;    // register selected
    } acc_dec_t;

    // Registers whose upper byte is read back through the latch
    function automatic logic slot_uses_latch(slot_e s);
        return (s == SLOT_CNT) || (s == SLOT_CAP);
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(logic [WORD_W-1:0] w, logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tbb_decode.sv
`timescale 1ns/1ps
module tbb_decode
    import timer_byte_bridge_pkg::*;
#(
    parameter int A_W  = ADDR_W,
    parameter int N_W  = NUM_WIDE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] addr,
    input  logic           wr,
    input  logic           rd,
    output acc_dec_t       dec
);
    localparam int S_W = $clog2(N_W);

    logic           is_hi;
    logic [S_W-1:0] slot_idx;
    logic           in_map;

    assign is_hi    = addr[0];
    assign slot_idx = addr[S_W:1];

    generate
        if (A_W > S_W + 1) begin : g_wide_addr
            assign in_map = (addr[A_W-1:S_W+1] == '0);
        end else begin : g_exact_addr
            assign in_map = 1'b1;
        end
    endgenerate

    generate
        for (genvar g = 0; g < N_W; g++) begin : g_slot
            localparam logic LATCHED = (g == int'(SLOT_CNT)) || (g == int'(SLOT_CAP));
            logic sel;
            assign sel = in_map && !is_hi && (slot_idx == S_W'(g));
            assign dec.ld_lo[g] = wr && sel;
            assign dec.snap[g]  = rd && sel && LATCHED;
        end
    endgenerate

    assign dec.hi_wr = wr && in_map && is_hi;
    assign dec.hit   = in_map;
    assign dec.rd_hi = is_hi;
    assign dec.slot  = slot_e'(slot_idx);

    // At most one register is addressed per cycle
    assert_ld_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec.ld_lo));
    assert_snap_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec.snap));
    assert_hi_wr_excl_R2: assert property (@(posedge clk) disable iff (rst)
        dec.hi_wr |-> (dec.ld_lo == '0));

endmodule

// File: rtl/tbb_shadow.sv
`timescale 1ns/1ps
module tbb_shadow
    import timer_byte_bridge_pkg::*;
#(
    parameter int B_W = BYTE_W,
    parameter int N_W = NUM_WIDE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hi_wr,
    input  logic [N_W-1:0]          snap,
    input  logic [B_W-1:0]          wdata,
    input  logic [N_W-1:0][B_W-1:0] hi_bytes,
    output logic [B_W-1:0]          tmp_q
);
    logic [B_W-1:0] snap_byte;
    logic           snap_any;

    always_comb begin
        snap_byte = '0;
        for (int i = 0; i < N_W; i++) begin
            if (snap[i]) snap_byte = hi_bytes[i];
        end
    end

    assign snap_any = |snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmp_q <= '0;
        end else if (hi_wr) begin
            tmp_q <= wdata;
        end else if (snap_any) begin
            tmp_q <= snap_byte;
        end
    end

    // Upper-byte write lands in the latch
    assert_hi_wr_fills_R2: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> tmp_q == $past(wdata));
    // Counter lower-byte read freezes the counter's upper byte
    assert_cnt_snap_R4: assert property (@(posedge clk) disable iff (rst)
        (snap[SLOT_CNT] && !hi_wr) |=> tmp_q == $past(hi_bytes[SLOT_CNT]));
    assert_cap_snap_R4: assert property (@(posedge clk) disable iff (rst)
        (snap[SLOT_CAP] && !hi_wr) |=> tmp_q == $past(hi_bytes[SLOT_CAP]));
    // Other accesses leave it alone
    assert_tmp_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (!hi_wr && !snap_any) |=> $stable(tmp_q));

endmodule

// File: rtl/tbb_regs.sv
`timescale 1ns/1ps
module tbb_regs
    import timer_byte_bridge_pkg::*;
#(
    parameter int B_W = BYTE_W,
    parameter int W_W = WORD_W,
    parameter int N_W = NUM_WIDE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_W-1:0]          ld_lo,
    input  logic [B_W-1:0]          wdata,
    input  logic [B_W-1:0]          tmp_q,
    input  logic                    cnt_en,
    input  logic                    cap_stb,
    input  logic [W_W-1:0]          cap_val,
    output logic [N_W-1:0][W_W-1:0] regs_q
);
    logic [W_W-1:0] commit_word;
    assign commit_word = {tmp_q, wdata};

    generate
        for (genvar g = 0; g < N_W; g++) begin : g_word
            if (g == int'(SLOT_CNT)) begin : g_counter
                always_ff @(posedge clk) begin
                    if (rst)           regs_q[g] <= '0;
                    else if (ld_lo[g]) regs_q[g] <= commit_word;
                    else if (cnt_en)   regs_q[g] <= regs_q[g] + W_W'(1);
                end
                assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
                    (cnt_en && !ld_lo[g]) |=> regs_q[g] == $past(regs_q[g]) + W_W'(1));
                assert_cnt_wr_wins_R8: assert property (@(posedge clk) disable iff (rst)
                    (cnt_en && ld_lo[g]) |=> regs_q[g] == $past(commit_word));
                assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (rst)
                    (!cnt_en && !ld_lo[g]) |=> $stable(regs_q[g]));
            end else if (g == int'(SLOT_CAP)) begin : g_capture
                always_ff @(posedge clk) begin
                    if (rst)           regs_q[g] <= '0;
                    else if (ld_lo[g]) regs_q[g] <= commit_word;
                    else if (cap_stb)  regs_q[g] <= cap_val;
                end
                assert_cap_load_R9: assert property (@(posedge clk) disable iff (rst)
                    (cap_stb && !ld_lo[g]) |=> regs_q[g] == $past(cap_val));
                assert_cap_wr_wins_R9: assert property (@(posedge clk) disable iff (rst)
                    (cap_stb && ld_lo[g]) |=> regs_q[g] == $past(commit_word));
            end else begin : g_compare
                always_ff @(posedge clk) begin
                    if (rst)           regs_q[g] <= '0;
                    else if (ld_lo[g]) regs_q[g] <= commit_word;
                end
                assert_cmp_commit_R3: assert property (@(posedge clk) disable iff (rst)
                    ld_lo[g] |=> regs_q[g] == $past(commit_word));
                assert_cmp_hold_R2: assert property (@(posedge clk) disable iff (rst)
                    !ld_lo[g] |=> $stable(regs_q[g]));
            end
        end
    endgenerate

endmodule

// File: rtl/timer_byte_bridge.sv
`timescale 1ns/1ps
module timer_byte_bridge
    import timer_byte_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_en,
    input  logic              cap_stb,
    input  logic [WORD_W-1:0] cap_val,
    output logic [WORD_W-1:0] cnt_q,
    output logic [WORD_W-1:0] cmpa_q,
    output logic [WORD_W-1:0] cmpb_q,
    output logic [WORD_W-1:0] cap_q
);
    acc_dec_t                             dec;
    logic [BYTE_W-1:0]                    tmp_q;
    logic [NUM_WIDE-1:0][WORD_W-1:0]      regs_q;
    logic [NUM_WIDE-1:0][BYTE_W-1:0]      hi_bytes;

    tbb_decode #(.A_W(ADDR_W), .N_W(NUM_WIDE)) u_decode (
        .clk  (clk),
        .rst  (rst),
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .dec  (dec)
    );

    generate
        for (genvar g = 0; g < NUM_WIDE; g++) begin : g_hi
            assign hi_bytes[g] = regs_q[g][WORD_W-1:BYTE_W];
        end
    endgenerate

    tbb_shadow #(.B_W(BYTE_W), .N_W(NUM_WIDE)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .hi_wr    (dec.hi_wr),
        .snap     (dec.snap),
        .wdata    (bus_wdata),
        .hi_bytes (hi_bytes),
        .tmp_q    (tmp_q)
    );

    tbb_regs #(.B_W(BYTE_W), .W_W(WORD_W), .N_W(NUM_WIDE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ld_lo   (dec.ld_lo),
        .wdata   (bus_wdata),
        .tmp_q   (tmp_q),
        .cnt_en  (cnt_en),
        .cap_stb (cap_stb),
        .cap_val (cap_val),
        .regs_q  (regs_q)
    );

    always_comb begin
        if (!dec.hit)
            bus_rdata = '0;
        else if (dec.rd_hi && slot_uses_latch(dec.slot))
            bus_rdata = tmp_q;
        else
            bus_rdata = pick_byte(regs_q[dec.slot], dec.rd_hi);
    end

    assign cnt_q  = regs_q[SLOT_CNT];
    assign cmpa_q = regs_q[SLOT_CMPA];
    assign cmpb_q = regs_q[SLOT_CMPB];
    assign cap_q  = regs_q[SLOT_CAP];

    assert_rw_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr >= ADDR_W'(2*NUM_WIDE))) |-> bus_rdata == '0);
    assert_cmp_direct_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(3)) |-> bus_rdata == cmpa_q[WORD_W-1:BYTE_W]);
    assert_cnt_hi_latched_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(1)) |-> bus_rdata == tmp_q);

endmodule

// File: tb/timer_byte_bridge_tb_top.sv
`timescale 1ns/1ps
module timer_byte_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cnt_en = 1'b0;
    logic        cap_stb = 1'b0;
    logic [15:0] cap_val = '0;
    logic [15:0] cnt_q, cmpa_q, cmpb_q, cap_q;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    timer_byte_bridge dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cnt_en(cnt_en), .cap_stb(cap_stb), .cap_val(cap_val),
        .cnt_q(cnt_q), .cmpa_q(cmpa_q), .cmpb_q(cmpb_q), .cap_q(cap_q)
    );

    // Monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        if (bus_rd) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s read addr %0d: actual %02h expected %02h",
                             t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk16(input string t, input logic [15:0] act, input logic [15:0] e);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %04h expected %04h", t, act, e);
        end
    endtask

    task automatic count_for(input int n);
        @(posedge clk); #1;
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 cnt_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk16("R1 cnt", cnt_q, 16'h0);
        chk16("R1 cmpa", cmpa_q, 16'h0);
        chk16("R1 cmpb", cmpb_q, 16'h0);
        chk16("R1 cap", cap_q, 16'h0);
        bus_read(4'd1, 8'h00, "R1");

        // Upper then lower write to counter
        bus_write(4'd1, 8'h01);
        @(negedge clk); chk16("R2 cnt untouched", cnt_q, 16'h0000);
        bus_write(4'd0, 8'hFF);
        @(negedge clk); chk16("R3 cnt commit", cnt_q, 16'h01FF);

        // Lower read freezes upper, counter then moves on
        bus_read(4'd0, 8'hFF, "R4");
        count_for(4);
        @(negedge clk); chk16("R8 cnt count", cnt_q, 16'h0203);
        bus_read(4'd1, 8'h01, "R5");

        // Compare registers
        bus_write(4'd3, 8'hA5);
        @(negedge clk); chk16("R2 cmpa untouched", cmpa_q, 16'h0000);
        bus_write(4'd2, 8'h5A);
        @(negedge clk); chk16("R3 cmpa commit", cmpa_q, 16'hA55A);
        bus_write(4'd5, 8'h0F);
        bus_write(4'd4, 8'hF0);
        @(negedge clk); chk16("R3 cmpb commit", cmpb_q, 16'h0FF0);

        // Compare reads bypass the latch
        bus_write(4'd1, 8'hC3);
        @(negedge clk); chk16("R2 cnt untouched", cnt_q, 16'h0203);
        bus_read(4'd3, 8'hA5, "R6");
        bus_read(4'd2, 8'h5A, "R6");
        bus_read(4'd4, 8'hF0, "R6");
        bus_read(4'd5, 8'h0F, "R6");
        bus_write(4'd0, 8'h00);
        @(negedge clk); chk16("R6 latch kept", cnt_q, 16'hC300);

        // Shared latch across registers
        bus_write(4'd7, 8'h3C);
        @(negedge clk); chk16("R2 cap untouched", cap_q, 16'h0000);
        bus_write(4'd0, 8'h11);
        @(negedge clk); chk16("R7 shared latch", cnt_q, 16'h3C11);

        // Write beats increment
        cnt_en = 1'b1;
        bus_write(4'd1, 8'h12);
        bus_write(4'd0, 8'h34);
        cnt_en = 1'b0;
        @(negedge clk); chk16("R8 write wins", cnt_q, 16'h1234);

        // Wrap
        bus_write(4'd1, 8'hFF);
        bus_write(4'd0, 8'hFF);
        count_for(2);
        @(negedge clk); chk16("R8 wrap", cnt_q, 16'h0001);

        // Capture
        @(posedge clk); #1;
        cap_val = 16'hBEEF; cap_stb = 1'b1;
        @(posedge clk); #1;
        cap_stb = 1'b0;
        @(negedge clk); chk16("R9 capture", cap_q, 16'hBEEF);
        bus_read(4'd6, 8'hEF, "R4");
        @(posedge clk); #1;
        cap_val = 16'h1234; cap_stb = 1'b1;
        @(posedge clk); #1;
        cap_stb = 1'b0;
        bus_read(4'd7, 8'hBE, "R5");
        bus_read(4'd6, 8'h34, "R4");
        bus_read(4'd7, 8'h12, "R5");

        // Capture strobe loses to lower-byte write
        bus_write(4'd7, 8'h55);
        @(posedge clk); #1;
        bus_addr = 4'd6; bus_wdata = 8'h66; bus_wr = 1'b1;
        cap_val = 16'hABCD; cap_stb = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; cap_stb = 1'b0;
        @(negedge clk); chk16("R9 write wins", cap_q, 16'h5566);

        // Unmapped
        bus_read(4'd9, 8'h00, "R10");
        bus_read(4'd15, 8'h00, "R10");

        repeat (3) @(posedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule